// File: doc/BRIEF.md
# Error Interrupt Status Aggregator

This block collects single-cycle error pulses from six hardware sources and holds each one in a sticky raw status bit until software acknowledges it. A per-source enable mask decides which latched errors reach the interrupt line. Software reads both an unmasked and a masked view of the status through a 32-bit register port. It acknowledges an error by writing ones to the masked status register.

Two level outputs are produced. `irq_err` is high while any enabled error is pending. `irq_fatal` is high while an enabled error from the fatal subset is pending; that subset is the fatal error bit and the tag-lookup fatal bit. The enable mask has no plain read/write register. Bits are turned on through a set register and turned off through a clear register, so one source can be changed without a read-modify-write.

Top module: `err_irq_aggregator`

## Requirements
- R1: Source bit positions are fixed: bit 0 system summary error, bit 1 fatal error, bit 2 non-fatal error, bit 3 correctable error, bit 4 tag-lookup fatal error, bit 5 end-to-end CRC error. The fatal subset is bits 1 and 4 (mask 0x12).
- R2: Register offsets: 0x1c0 reads raw status; 0x1c4 reads raw AND enable; 0x1c8 and 0x1cc both read the enable mask; any other offset reads zero. Read data and `bus_rvalid` appear on the clock edge after the cycle that carries the read request.
- R3: A high `err_evt[i]` sets raw bit i at the next clock edge, whether or not the source is enabled. The bit then stays set until it is cleared.
- R4: A write to 0x1c8 ORs `bus_wdata[5:0]` into the enable mask. A write to 0x1cc clears each enable bit whose `bus_wdata` bit is one. Writing 0x3f to 0x1c8 enables all sources.
- R5: A write to 0x1c4 clears each raw bit whose `bus_wdata` bit is one, enabled or not; zero bits have no effect. Writes to 0x1c0 change nothing.
- R6: `irq_err` is high exactly when raw AND enable is nonzero.
- R7: `irq_fatal` is high exactly when raw AND enable AND 0x12 is nonzero.
- R8: If an event and a write-one-to-clear hit the same bit in the same cycle, the bit is set after the edge.
- R9: Register bits 31..6 always read zero, and write data in those bits is ignored. Reset clears raw status, the enable mask, read data and both outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_evt | input | 6 | Error event pulses, one bit per source |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read request |
| irq_err | output | 1 | Any enabled error pending |
| irq_fatal | output | 1 | Any enabled fatal-subset error pending |

## Verification
The bench builds the block with its default parameters: six sources, 32-bit data, 12-bit offsets and fatal mask 0x12. With these values every source bit, the full 32-bit read word and both fatal bits can be reached through the ports. The register width leaves 26 upper bits, so writes of all ones can be checked for having no effect above bit 5. The small source count lets each directed scenario cover set-versus-clear collisions, fatal and non-fatal bits pending together, and all-ones writes to every register.

// File: rtl/err_agg_pkg.sv
package err_agg_pkg;

    // Register selected by the current bus request
    typedef enum logic [2:0] {
        SEL_NONE   = 3'd0,
        SEL_RAW    = 3'd1,
        SEL_MASKED = 3'd2,
        SEL_EN_SET = 3'd3,
        SEL_EN_CLR = 3'd4
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     wr;
        logic     rd;
    } bus_op_t;

endpackage

// File: rtl/err_agg_regif.sv
module err_agg_regif
    import err_agg_pkg::*;
#(
    parameter int                 NUM_SRC    = 6,
    parameter int                 DATA_W     = 32,
    parameter int                 ADDR_W     = 12,
    parameter logic [ADDR_W-1:0]  OFS_RAW    = 12'h1c0,
    parameter logic [ADDR_W-1:0]  OFS_MASKED = 12'h1c4,
    parameter logic [ADDR_W-1:0]  OFS_EN_SET = 12'h1c8,
    parameter logic [ADDR_W-1:0]  OFS_EN_CLR = 12'h1cc
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [NUM_SRC-1:0] raw_bits,
    input  logic [NUM_SRC-1:0] en_bits,
    output logic               set_en,
    output logic               clr_en,
    output logic               w1c_en,
    output logic [NUM_SRC-1:0] wbits,
    output logic [DATA_W-1:0]  rdata,
    output logic               rvalid
);
    localparam int PAD_W = DATA_W - NUM_SRC;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } rd_state_t;

    bus_op_t           op;
    rd_state_t         st_d, st_q;
    logic [NUM_SRC-1:0] sel_bits;
    logic              wdata_unused;

    assign wdata_unused = ^bus_wdata[DATA_W-1:NUM_SRC];

    always_comb begin
        op.wr = bus_valid & bus_write;
        op.rd = bus_valid & ~bus_write;
        if (bus_addr == OFS_RAW)         op.sel = SEL_RAW;
        else if (bus_addr == OFS_MASKED) op.sel = SEL_MASKED;
        else if (bus_addr == OFS_EN_SET) op.sel = SEL_EN_SET;
        else if (bus_addr == OFS_EN_CLR) op.sel = SEL_EN_CLR;
        else                             op.sel = SEL_NONE;
    end

    assign set_en = op.wr & (op.sel == SEL_EN_SET);
    assign clr_en = op.wr & (op.sel == SEL_EN_CLR);
    assign w1c_en = op.wr & (op.sel == SEL_MASKED);
    assign wbits  = bus_wdata[NUM_SRC-1:0];

    always_comb begin
        case (op.sel)
            SEL_RAW:    sel_bits = raw_bits;
            SEL_MASKED: sel_bits = raw_bits & en_bits;
            SEL_EN_SET,
            SEL_EN_CLR: sel_bits = en_bits;
            default:    sel_bits = '0;
        endcase
        st_d.rvalid = op.rd;
        st_d.rdata  = op.rd ? {{PAD_W{1'b0}}, sel_bits} : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata  = st_q.rdata;
    assign rvalid = st_q.rvalid;
endmodule

// File: rtl/err_agg_enable.sv
module err_agg_enable #(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic               clr_en,
    input  logic [NUM_SRC-1:0] wbits,
    output logic [NUM_SRC-1:0] en_bits
);
    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_en) st_d.mask = st_q.mask | wbits;
        if (clr_en) st_d.mask = st_q.mask & ~wbits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_bits = st_q.mask;
endmodule

// File: rtl/err_agg_status.sv
module err_agg_status #(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] err_evt,
    input  logic               w1c_en,
    input  logic [NUM_SRC-1:0] wbits,
    output logic [NUM_SRC-1:0] raw_bits
);
    // One sticky cell per source; a new event outranks a same-cycle clear
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
        logic bit_d, bit_q;

        always_comb begin
            bit_d = bit_q;
            if (w1c_en && wbits[g]) bit_d = 1'b0;
            if (err_evt[g])         bit_d = 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= bit_d;
        end

        assign raw_bits[g] = bit_q;
    end
endmodule

// File: rtl/err_irq_aggregator.sv
module err_irq_aggregator #(
    parameter int                 NUM_SRC    = 6,
    parameter int                 DATA_W     = 32,
    parameter int                 ADDR_W     = 12,
    parameter logic [ADDR_W-1:0]  OFS_RAW    = 12'h1c0,
    parameter logic [ADDR_W-1:0]  OFS_MASKED = 12'h1c4,
    parameter logic [ADDR_W-1:0]  OFS_EN_SET = 12'h1c8,
    parameter logic [ADDR_W-1:0]  OFS_EN_CLR = 12'h1cc,
    parameter logic [NUM_SRC-1:0] FATAL_MASK = 6'h12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] err_evt,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_rvalid,
    output logic               irq_err,
    output logic               irq_fatal
);
    logic               set_en, clr_en, w1c_en;
    logic [NUM_SRC-1:0] wbits, raw_bits, en_bits, masked;

    err_agg_regif #(
        .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .OFS_RAW(OFS_RAW), .OFS_MASKED(OFS_MASKED),
        .OFS_EN_SET(OFS_EN_SET), .OFS_EN_CLR(OFS_EN_CLR)
    ) u_regif (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .raw_bits(raw_bits), .en_bits(en_bits),
        .set_en(set_en), .clr_en(clr_en), .w1c_en(w1c_en), .wbits(wbits),
        .rdata(bus_rdata), .rvalid(bus_rvalid)
    );

    err_agg_enable #(.NUM_SRC(NUM_SRC)) u_enable (
        .clk(clk), .rst_n(rst_n),
        .set_en(set_en), .clr_en(clr_en), .wbits(wbits),
        .en_bits(en_bits)
    );

    err_agg_status #(.NUM_SRC(NUM_SRC)) u_status (
        .clk(clk), .rst_n(rst_n),
        .err_evt(err_evt), .w1c_en(w1c_en), .wbits(wbits),
        .raw_bits(raw_bits)
    );

    assign masked    = raw_bits & en_bits;
    assign irq_err   = |masked;
    assign irq_fatal = |(masked & FATAL_MASK);
endmodule

// File: rtl/err_agg_chk.sv
module err_agg_chk #(
    parameter int                 NUM_SRC    = 6,
    parameter int                 DATA_W     = 32,
    parameter int                 ADDR_W     = 12,
    parameter logic [ADDR_W-1:0]  OFS_RAW    = 12'h1c0,
    parameter logic [ADDR_W-1:0]  OFS_MASKED = 12'h1c4,
    parameter logic [ADDR_W-1:0]  OFS_EN_SET = 12'h1c8,
    parameter logic [ADDR_W-1:0]  OFS_EN_CLR = 12'h1cc,
    parameter logic [NUM_SRC-1:0] FATAL_MASK = 6'h12
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] err_evt,
    input logic               bus_valid,
    input logic               bus_write,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               bus_rvalid,
    input logic               irq_err,
    input logic               irq_fatal,
    input logic [NUM_SRC-1:0] raw_bits,
    input logic [NUM_SRC-1:0] en_bits
);
    logic               wr_set, wr_clr, wr_w1c, wr_raw;
    logic [NUM_SRC-1:0] wb;

    assign wr_set = bus_valid && bus_write && bus_addr == OFS_EN_SET;
    assign wr_clr = bus_valid && bus_write && bus_addr == OFS_EN_CLR;
    assign wr_w1c = bus_valid && bus_write && bus_addr == OFS_MASKED;
    assign wr_raw = bus_valid && bus_write && bus_addr == OFS_RAW;
    assign wb     = bus_wdata[NUM_SRC-1:0];

    // R3: an event is latched at the next edge
    assert_evt_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_evt) |=> ((raw_bits & $past(err_evt)) == $past(err_evt)));

    // R8: a same-cycle clear loses to the event
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_w1c && |(err_evt & wb)) |=> ((raw_bits & $past(err_evt & wb)) == $past(err_evt & wb)));

    // R5: write-one-to-clear removes written bits that had no new event
    assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_w1c |=> ((raw_bits & $past(wb & ~err_evt)) == '0));

    // R5: a write to the raw register leaves it unchanged apart from events
    assert_raw_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_raw && err_evt == '0) |=> $stable(raw_bits));

    // R4: set and clear of the enable mask
    assert_en_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((en_bits & $past(wb)) == $past(wb)));
    assert_en_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((en_bits & $past(wb)) == '0));

    // R6 / R7: interrupt levels follow the masked status
    assert_irq_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err == (|(raw_bits & en_bits)));
    assert_fatal_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fatal == (|(raw_bits & en_bits & FATAL_MASK)));
    assert_fatal_in_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fatal |-> irq_err);

    // R2 / R9: read data is timed by the request and upper bits stay zero
    assert_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> bus_rvalid);
    assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NUM_SRC] == '0);
endmodule

bind err_irq_aggregator err_agg_chk #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .OFS_RAW(OFS_RAW), .OFS_MASKED(OFS_MASKED),
    .OFS_EN_SET(OFS_EN_SET), .OFS_EN_CLR(OFS_EN_CLR),
    .FATAL_MASK(FATAL_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq_err(irq_err), .irq_fatal(irq_fatal),
    .raw_bits(raw_bits), .en_bits(en_bits)
);

// File: tb/sim_err_irq_aggregator.sv
module sim_err_irq_aggregator;
    localparam logic [11:0] A_RAW = 12'h1c0;
    localparam logic [11:0] A_MSK = 12'h1c4;
    localparam logic [11:0] A_SET = 12'h1c8;
    localparam logic [11:0] A_CLR = 12'h1cc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  err_evt = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        irq_err, irq_fatal;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    err_irq_aggregator u0 (
        .clk(clk), .rst_n(rst_n), .err_evt(err_evt),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .irq_err(irq_err), .irq_fatal(irq_fatal)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(posedge clk);
        #1;
        d = bus_rdata;
        check("R2 rvalid", {31'd0, bus_rvalid}, 32'd1);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_rd(a, v);
        check(req, v, exp);
    endtask

    task automatic pulse(input logic [5:0] bits);
        @(negedge clk);
        err_evt = bits;
        @(negedge clk);
        err_evt = '0;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        check("R9 irq_err after reset", {31'd0, irq_err}, 32'd0);
        check("R9 irq_fatal after reset", {31'd0, irq_fatal}, 32'd0);
        check("R9 rvalid idle after reset", {31'd0, bus_rvalid}, 32'd0);
        expect_reg("R9 raw after reset", A_RAW, 32'h0);
        expect_reg("R9 masked after reset", A_MSK, 32'h0);
        expect_reg("R9 enable after reset", A_SET, 32'h0);
    endtask

    task automatic t_latch_disabled();
        pulse(6'h04);                                   // bit 2 non-fatal
        expect_reg("R3 raw latched while disabled", A_RAW, 32'h04);
        expect_reg("R2 masked zero while disabled", A_MSK, 32'h0);
        check("R6 irq low while disabled", {31'd0, irq_err}, 32'd0);
        repeat (3) @(negedge clk);
        expect_reg("R3 raw sticky", A_RAW, 32'h04);
    endtask

    task automatic t_enable_all();
        bus_wr(A_SET, 32'h3f);
        expect_reg("R4 enable via set offset", A_SET, 32'h3f);
        expect_reg("R2 enable via clear offset", A_CLR, 32'h3f);
        expect_reg("R2 masked view", A_MSK, 32'h04);
        check("R6 irq high", {31'd0, irq_err}, 32'd1);
        check("R7 non-fatal not fatal", {31'd0, irq_fatal}, 32'd0);
    endtask

    task automatic t_fatal();
        pulse(6'h10);                                   // bit 4 tag-lookup fatal
        check("R7 fatal from bit4", {31'd0, irq_fatal}, 32'd1);
        bus_wr(A_MSK, 32'h10);
        check("R7 fatal cleared", {31'd0, irq_fatal}, 32'd0);
        check("R6 irq still high from bit2", {31'd0, irq_err}, 32'd1);
        pulse(6'h02);                                   // bit 1 fatal
        check("R7 fatal from bit1", {31'd0, irq_fatal}, 32'd1);
        pulse(6'h29);                                   // bits 0,3,5 non-fatal
        expect_reg("R1 raw bits", A_RAW, 32'h2f);
        bus_wr(A_MSK, 32'h02);
        check("R1 bits 0,3,5 not fatal", {31'd0, irq_fatal}, 32'd0);
        bus_wr(A_MSK, 32'h29);
    endtask

    task automatic t_clear();
        bus_wr(A_RAW, 32'hffff_ffff);
        expect_reg("R5 raw write ignored", A_RAW, 32'h04);
        bus_wr(A_MSK, 32'h00);
        expect_reg("R5 zero write no effect", A_RAW, 32'h04);
        bus_wr(A_MSK, 32'h04);
        expect_reg("R5 w1c clears", A_RAW, 32'h0);
        check("R6 irq low after clear", {31'd0, irq_err}, 32'd0);
    endtask

    task automatic t_enable_clear();
        pulse(6'h08);
        bus_wr(A_CLR, 32'h08);
        expect_reg("R4 enable bit3 cleared", A_CLR, 32'h37);
        check("R6 irq low when masked", {31'd0, irq_err}, 32'd0);
        expect_reg("R3 raw kept when masked", A_RAW, 32'h08);
        bus_wr(A_SET, 32'h08);
        check("R6 irq high when re-enabled", {31'd0, irq_err}, 32'd1);
        bus_wr(A_CLR, 32'h08);
        bus_wr(A_MSK, 32'h08);                         // clears a disabled bit
        expect_reg("R5 w1c clears disabled bit", A_RAW, 32'h0);
        bus_wr(A_SET, 32'h08);
    endtask

    task automatic t_collision();
        pulse(6'h20);
        @(negedge clk);
        err_evt = 6'h01;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = A_MSK; bus_wdata = 32'h21;
        @(negedge clk);
        err_evt = '0; bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
        expect_reg("R8 event wins over clear", A_RAW, 32'h01);
        bus_wr(A_MSK, 32'h01);
        expect_reg("R8 clear after collision", A_RAW, 32'h0);
    endtask

    task automatic t_upper();
        bus_wr(A_CLR, 32'hffff_ffc0);
        expect_reg("R9 upper clear bits ignored", A_SET, 32'h3f);
        pulse(6'h3f);
        expect_reg("R9 raw upper zero", A_RAW, 32'h3f);
        expect_reg("R2 unmapped reads zero", 12'h1d0, 32'h0);
        expect_reg("R2 offset 0 reads zero", 12'h000, 32'h0);
    endtask

    task automatic t_mid_reset();
        apply_reset();
        check("R9 irq cleared by reset", {31'd0, irq_err}, 32'd0);
        check("R9 fatal cleared by reset", {31'd0, irq_fatal}, 32'd0);
        expect_reg("R9 raw cleared by reset", A_RAW, 32'h0);
        expect_reg("R9 enable cleared by reset", A_CLR, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latch_disabled();
        t_enable_all();
        t_fatal();
        t_clear();
        t_enable_clear();
        t_collision();
        t_upper();
        t_mid_reset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule